// File: doc/BRIEF.md
# Optical-Black Level Averager

This block measures the black level of an image sensor line by averaging converter samples taken from the optical-black pixels. A calibration window opens on each line when an active-low strobe is seen low at a clock edge. The first few samples of the window are skipped to line up with the converter's pipeline delay, and the samples after them are summed. When a programmed number of lines has been summed, the block divides the total by the number of samples taken and presents the result with a one-cycle done strobe.

The number of pixels taken per line is a power of two, or three times a power of two when the multiplier input is set. The number of lines taken is a power of two. Both exponents are capped at fixed maxima. While the window is open, a flag tells the analog path to add its anti-clipping offset. A clear pulse throws away any partial sum and starts the line count again.

The controller is a state machine with six states. `ST_IDLE` waits for the strobe. `ST_SKIP` counts out the latency pixels. `ST_ACC` sums the black pixels. `ST_LOAD` forms the shifted average. `ST_DIV` runs the divide by three. `ST_FIN` publishes the result. The transitions are:
- strobe-seen: `ST_IDLE` to `ST_SKIP`.
- skip-done: `ST_SKIP` to `ST_ACC`.
- line-more: `ST_ACC` to `ST_IDLE`.
- line-last: `ST_ACC` to `ST_LOAD`.
- no-triple: `ST_LOAD` to `ST_FIN`.
- triple: `ST_LOAD` to `ST_DIV`.
- div-last: `ST_DIV` to `ST_FIN`.
- publish: `ST_FIN` to `ST_IDLE`.
- clear: from any state to `ST_IDLE`.

Top module: `ob_black_averager`

## Requirements
- R1: During reset and at its release, `avg_o` is 0 and `done_o` is 0. `offs_add_o` is 0 at the same times.
- R2: A window starts only from idle, when `cal_ni` is sampled low at a rising clock edge. `offs_add_o` is then high for exactly SKIP_CNT+P clock cycles, where P is the number of pixels per line and SKIP_CNT defaults to 3. It rises in the cycle right after that edge.
- R3: P is 2^N, where N is `pix_exp_i`. An N above 6 is treated as 6, which gives 64 pixels.
- R4: With `triple_i` set, P is 3·2^N, up to 192 pixels. The result is then floor(floor(S / 2^(N+L)) / 3), where S is the sum of the samples.
- R5: The number of lines taken is 2^L, where L is `line_exp_i`. An L above 8 is treated as 8, which gives 256 lines.
- R6: Without the multiplier, the result is floor(S / 2^(N+L)). N and L here are the capped values.
- R7: `done_o` is a single-cycle pulse. It rises 2 clock edges after the edge that takes the last pixel of the last line, or 14 edges after it with the multiplier. `avg_o` changes only together with `done_o` and holds its value between pulses. The line count then restarts from zero.
- R8: A low `cal_ni` has no effect while a window, a division or a publish is in progress.
- R9: The values of `pix_exp_i`, `triple_i` and `line_exp_i` are captured at the strobe that starts the first line of a set. Changes to them during the rest of the set are ignored.
- R10: A high `clr_i` at a clock edge ends any open window or division. It discards the partial sum and sets the line count to zero, so the next strobe captures the configuration again. It takes priority over a strobe in the same cycle. `avg_o` keeps its value.
- R11: The first SKIP_CNT samples of every window are excluded from the sum. Only the following P samples are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 10 | Converter sample |
| cal_ni | input | 1 | Calibration strobe, active low |
| pix_exp_i | input | 4 | Pixels-per-line exponent N |
| triple_i | input | 1 | Multiply pixel count by three |
| line_exp_i | input | 4 | Line-count exponent L |
| clr_i | input | 1 | Discard accumulation |
| avg_o | output | 10 | Averaged black level |
| done_o | output | 1 | Result-valid pulse |
| offs_add_o | output | 1 | Add-offset flag covering the window |

## Verification
If the window or skip counter is wrong, the length of `offs_add_o` is wrong on the very first line. The reference model compares it on every clock, so the error shows at once. If the line counter or the captured configuration is wrong, `done_o` comes at the wrong time, one set later at the most. A wrong sum, shift or divide-by-three step shows up only in `avg_o` at the next done pulse. For that reason, constant-sample runs are used, because their average is known by hand. These are mixed with random runs.

// File: rtl/ob_avg_pkg.sv
package ob_avg_pkg;

    localparam int EXP_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ACC,
        ST_LOAD,
        ST_DIV,
        ST_FIN
    } ob_state_e;

    typedef struct packed {
        logic [EXP_W-1:0] pix_exp;
        logic             triple;
        logic [EXP_W-1:0] line_exp;
    } ob_cfg_t;

endpackage

// File: rtl/ob_avg_cfg.sv
module ob_avg_cfg
    import ob_avg_pkg::*;
#(
    parameter int PIX_EXP_MAX  = 6,
    parameter int LINE_EXP_MAX = 8,
    parameter int PIX_CW       = 8,
    parameter int LINE_CW      = 9,
    parameter int SH_W         = 4
) (
    input  ob_cfg_t             cfg_i,
    output logic [PIX_CW-1:0]   pix_tot_o,
    output logic [LINE_CW-1:0]  line_tot_o,
    output logic [SH_W-1:0]     shift_o
);

    logic [EXP_W-1:0] n_eff;
    logic [EXP_W-1:0] l_eff;

    // Cap the exponents, then turn them into counts and a shift amount
    always_comb begin
        n_eff = (cfg_i.pix_exp > EXP_W'(PIX_EXP_MAX)) ? EXP_W'(PIX_EXP_MAX) : cfg_i.pix_exp;
        l_eff = (cfg_i.line_exp > EXP_W'(LINE_EXP_MAX)) ? EXP_W'(LINE_EXP_MAX) : cfg_i.line_exp;
        pix_tot_o  = cfg_i.triple ? (PIX_CW'(3) << n_eff) : (PIX_CW'(1) << n_eff);
        line_tot_o = LINE_CW'(1) << l_eff;
        shift_o    = SH_W'(n_eff) + SH_W'(l_eff);
    end

endmodule

// File: rtl/ob_avg_div3.sv
module ob_avg_div3 #(
    parameter int DW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          start_i,
    input  logic [DW-1:0] dvd_i,
    output logic [DW-1:0] quot_o,
    output logic          last_o
);

    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] q_sh;
    logic [1:0]    rem_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    trial;
    logic          ge3;
    logic [2:0]    trial_nx;

    // One restoring step per clock: quotient bits shift in from the right
    always_comb begin
        trial    = {rem_q, q_sh[DW-1]};
        ge3      = (trial >= 3'd3);
        trial_nx = ge3 ? (trial - 3'd3) : trial;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_sh  <= '0;
            rem_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            q_sh  <= dvd_i;
            rem_q <= '0;
            cnt_q <= CW'(DW);
        end else if (cnt_q != '0) begin
            q_sh  <= {q_sh[DW-2:0], ge3};
            rem_q <= trial_nx[1:0];
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign quot_o = q_sh;
    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/ob_black_averager.sv
module ob_black_averager
    import ob_avg_pkg::*;
#(
    parameter int SMP_W        = 10,
    parameter int PIX_EXP_MAX  = 6,
    parameter int LINE_EXP_MAX = 8,
    parameter int SKIP_CNT     = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             cal_ni,
    input  logic [3:0]       pix_exp_i,
    input  logic             triple_i,
    input  logic [3:0]       line_exp_i,
    input  logic             clr_i,
    output logic [SMP_W-1:0] avg_o,
    output logic             done_o,
    output logic             offs_add_o
);

    localparam int MAX_PIX = 3 * (1 << PIX_EXP_MAX);
    localparam int PIX_CW  = $clog2(MAX_PIX + 1);
    localparam int LINE_CW = LINE_EXP_MAX + 1;
    localparam int SH_W    = $clog2(PIX_EXP_MAX + LINE_EXP_MAX + 1);
    localparam int ACC_W   = SMP_W + PIX_EXP_MAX + LINE_EXP_MAX + 2;
    localparam int DIV_W   = SMP_W + 2;
    localparam int CNT_W   = $clog2(MAX_PIX + SKIP_CNT + 1);

    ob_state_e          state_q, state_nx;
    ob_cfg_t            cfg_q;
    logic [PIX_CW-1:0]  pix_tot;
    logic [LINE_CW-1:0] line_tot;
    logic [SH_W-1:0]    shift_amt;
    logic [CNT_W-1:0]   win_cnt;
    logic [LINE_CW-1:0] line_cnt;
    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   shifted;
    logic [DIV_W-1:0]   shifted_sat;
    logic [DIV_W-1:0]   res_q;
    logic [DIV_W-1:0]   div_quot;
    logic [DIV_W-1:0]   pub_val;
    logic               div_last;
    logic               div_start;
    logic               skip_end;
    logic               last_pix;
    logic               last_line;

    ob_avg_cfg #(
        .PIX_EXP_MAX (PIX_EXP_MAX),
        .LINE_EXP_MAX(LINE_EXP_MAX),
        .PIX_CW      (PIX_CW),
        .LINE_CW     (LINE_CW),
        .SH_W        (SH_W)
    ) u_cfg (
        .cfg_i     (cfg_q),
        .pix_tot_o (pix_tot),
        .line_tot_o(line_tot),
        .shift_o   (shift_amt)
    );

    ob_avg_div3 #(
        .DW(DIV_W)
    ) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .start_i(div_start),
        .dvd_i  (shifted_sat),
        .quot_o (div_quot),
        .last_o (div_last)
    );

    // Decode window boundaries and form the shifted average
    always_comb begin
        skip_end    = (win_cnt == CNT_W'(SKIP_CNT - 1));
        last_pix    = (state_q == ST_ACC) && (win_cnt == (CNT_W'(pix_tot) - CNT_W'(1)));
        last_line   = (line_cnt == (line_tot - LINE_CW'(1)));
        shifted     = acc_q >> shift_amt;
        shifted_sat = (|shifted[ACC_W-1:DIV_W]) ? '1 : shifted[DIV_W-1:0];
        div_start   = (state_q == ST_LOAD) && cfg_q.triple && !clr_i;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (clr_i) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (!cal_ni)  state_nx = ST_SKIP;
                ST_SKIP: if (skip_end) state_nx = ST_ACC;
                ST_ACC:  if (last_pix) state_nx = last_line ? ST_LOAD : ST_IDLE;
                ST_LOAD: state_nx = cfg_q.triple ? ST_DIV : ST_FIN;
                ST_DIV:  if (div_last) state_nx = ST_FIN;
                ST_FIN:  state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Counters, configuration capture and accumulator
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q    <= '{pix_exp: 4'd3, triple: 1'b0, line_exp: 4'd0};
            win_cnt  <= '0;
            line_cnt <= '0;
            acc_q    <= '0;
            res_q    <= '0;
        end else if (clr_i) begin
            win_cnt  <= '0;
            line_cnt <= '0;
            acc_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    win_cnt <= '0;
                    if (!cal_ni && (line_cnt == '0)) begin
                        cfg_q <= '{pix_exp: pix_exp_i, triple: triple_i, line_exp: line_exp_i};
                    end
                end
                ST_SKIP: begin
                    win_cnt <= skip_end ? '0 : (win_cnt + CNT_W'(1));
                end
                ST_ACC: begin
                    acc_q <= acc_q + ACC_W'(smp_i);
                    if (last_pix) begin
                        win_cnt  <= '0;
                        line_cnt <= line_cnt + LINE_CW'(1);
                    end else begin
                        win_cnt <= win_cnt + CNT_W'(1);
                    end
                end
                ST_LOAD: begin
                    res_q <= shifted_sat;
                end
                ST_FIN: begin
                    acc_q    <= '0;
                    line_cnt <= '0;
                end
                default: begin
                    win_cnt <= win_cnt;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pub_val    = cfg_q.triple ? div_quot : res_q;
        offs_add_o = (state_q == ST_SKIP) || (state_q == ST_ACC);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            avg_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_FIN) && !clr_i;
            if ((state_q == ST_FIN) && !clr_i) begin
                avg_o <= (|pub_val[DIV_W-1:SMP_W]) ? '1 : pub_val[SMP_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ob_black_averager_chk.sv
module ob_black_averager_chk #(
    parameter int SMP_W        = 10,
    parameter int PIX_EXP_MAX  = 6,
    parameter int SKIP_CNT     = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cal_ni,
    input logic             clr_i,
    input logic [SMP_W-1:0] avg_o,
    input logic             done_o,
    input logic             offs_add_o
);

    localparam int MAX_RUN = SKIP_CNT + 3 * (1 << PIX_EXP_MAX);

    logic [15:0] run_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_len <= '0;
        end else begin
            run_len <= offs_add_o ? (run_len + 16'd1) : 16'd0;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    avg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(avg_o) |-> done_o);

    // R7
    done_flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !offs_add_o);

    // R2
    flag_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(offs_add_o) |-> $past(!cal_ni));

    // R2
    flag_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_len <= 16'(MAX_RUN));

    // R10
    clr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!offs_add_o && !done_o));

endmodule

bind ob_black_averager ob_black_averager_chk #(
    .SMP_W      (SMP_W),
    .PIX_EXP_MAX(PIX_EXP_MAX),
    .SKIP_CNT   (SKIP_CNT)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cal_ni    (cal_ni),
    .clr_i     (clr_i),
    .avg_o     (avg_o),
    .done_o    (done_o),
    .offs_add_o(offs_add_o)
);

// File: tb/ob_black_averager_tb_top.sv
`timescale 1ns/1ps
module ob_black_averager_tb_top;

    localparam int SKIP = 3;
    localparam int QW   = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp = '0;
    logic       cal_n = 1'b1;
    logic [3:0] pexp = 4'd3;
    logic       trip = 1'b0;
    logic [3:0] lexp = 4'd0;
    logic       clr = 1'b0;
    logic [9:0] avg;
    logic       done;
    logic       flag;

    always #2 clk = ~clk;

    ob_black_averager dut_i (
        .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .cal_ni(cal_n),
        .pix_exp_i(pexp), .triple_i(trip), .line_exp_i(lexp), .clr_i(clr),
        .avg_o(avg), .done_o(done), .offs_add_o(flag)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  fin = 0;
    int  pat = 0;
    int  pval = 0;
    int  len = 0;
    bit  got = 0;

    // behavioural reference model
    int     m_win, m_tot, m_line, m_post, m_avg, m_n, m_l;
    bit     m_t, m_done;
    longint m_sum;

    function automatic int pix_of(int n, bit t);
        int ne = (n > 6) ? 6 : n;
        return (t ? 3 : 1) << ne;
    endfunction

    function automatic int lines_of(int l);
        return 1 << ((l > 8) ? 8 : l);
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = 0; m_tot = 0; m_line = 0; m_post = 0; m_avg = 0;
            m_n = 3; m_l = 0; m_t = 0; m_done = 0; m_sum = 0;
        end else begin
            m_done = 0;
            if (clr) begin
                m_win = 0; m_line = 0; m_post = 0; m_sum = 0;
            end else if (m_win > 0) begin
                if (m_tot - m_win >= SKIP) m_sum += smp;
                m_win--;
                if (m_win == 0) begin
                    m_line++;
                    if (m_line == lines_of(m_l)) m_post = m_t ? 2 + QW : 2;
                end
            end else if (m_post > 0) begin
                m_post--;
                if (m_post == 0) begin
                    m_avg = int'(m_sum >> (((m_n > 6) ? 6 : m_n) + ((m_l > 8) ? 8 : m_l)));
                    if (m_t) m_avg = m_avg / 3;
                    m_done = 1; m_line = 0; m_sum = 0;
                end
            end else if (!cal_n) begin
                if (m_line == 0) begin
                    m_n = pexp; m_t = trip; m_l = lexp;
                end
                m_tot = SKIP + pix_of(m_n, m_t);
                m_win = m_tot;
            end
        end
    end

    // sample driver
    always @(negedge clk) begin
        case (pat)
            1:       smp <= 10'(pval);
            2:       smp <= (m_win > 0 && (m_tot - m_win) < SKIP) ? 10'd1023 : 10'd0;
            default: smp <= 10'($urandom_range(0, 1023));
        endcase
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            check("R2", "offset flag", flag, (m_win > 0) ? 1 : 0);
            check("R7", "done strobe", done, m_done);
            check("R6", "average", avg, m_avg);
        end
    end

    task automatic one_line();
        @(negedge clk) cal_n = 1'b0;
        @(negedge clk) cal_n = 1'b1;
        len = 0;
        while (flag && len < 400) begin
            len++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wait_done(input string tag);
        got = 0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (done) got = 1;
            else @(negedge clk);
        end
        check(tag, "done seen", got, 1);
    endtask

    task automatic set_cfg(input int n, input bit t, input int l);
        pexp = 4'(n); trip = t; lexp = 4'(l);
    endtask

    task automatic finish_run();
        if (!fin) begin
            fin = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run not finished actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "avg in reset", avg, 0);
        check("R1", "done in reset", done, 0);
        check("R1", "flag in reset", flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "avg after reset", avg, 0);
        check("R1", "flag after reset", flag, 0);

        // R6 default sizing, constant samples
        pat = 1; pval = 500; set_cfg(3, 0, 0);
        one_line();
        check("R2", "window length N=3", len, SKIP + 8);
        wait_done("R6");
        check("R6", "average const 500", avg, 500);
        // R7 one-cycle pulse
        @(negedge clk);
        check("R7", "done drops", done, 0);

        // R5 two lines random samples (model compared)
        pat = 0; set_cfg(2, 0, 1);
        one_line(); one_line();
        wait_done("R5");

        // R3 exponent capped
        pat = 1; pval = 200; set_cfg(9, 0, 0);
        one_line();
        check("R3", "window length N capped", len, SKIP + 64);
        wait_done("R3");
        check("R3", "average N capped", avg, 200);

        // R4 multiplier with constant samples
        pat = 1; pval = 700; set_cfg(1, 1, 1);
        one_line();
        check("R4", "window length triple N=1", len, SKIP + 6);
        one_line();
        wait_done("R4");
        check("R4", "average triple", avg, 700);

        // R4 largest window, random samples
        pat = 0; set_cfg(6, 1, 2);
        for (int i = 0; i < 4; i++) begin
            one_line();
            check("R4", "window length 192", len, SKIP + 192);
        end
        wait_done("R4");

        // R5 line exponent capped at 256 lines
        pat = 1; pval = 9; set_cfg(0, 0, 12);
        for (int i = 0; i < lines_of(12); i++) begin
            one_line();
            if (i < lines_of(12) - 1) check("R5", "no early done", done, 0);
        end
        wait_done("R5");
        check("R5", "average 256 lines", avg, 9);

        // R11 skipped samples excluded
        pat = 2; set_cfg(2, 0, 0);
        one_line();
        wait_done("R11");
        check("R11", "skip samples excluded", avg, 0);

        // R9 configuration change mid-set ignored
        pat = 1; pval = 321; set_cfg(2, 0, 1);
        one_line();
        set_cfg(5, 1, 0);
        one_line();
        check("R9", "second line keeps N=2", len, SKIP + 4);
        wait_done("R9");
        check("R9", "average after change", avg, 321);

        // R8 strobe held low through whole set
        pat = 1; pval = 77; set_cfg(1, 0, 1);
        @(negedge clk) cal_n = 1'b0;
        got = 0;
        for (int k = 0; k < 60 && !got; k++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        cal_n = 1'b1;
        check("R8", "done with strobe held", got, 1);
        check("R8", "average with strobe held", avg, 77);
        repeat (12) @(negedge clk);

        // R10 clear mid-window
        pat = 1; pval = 100; set_cfg(3, 0, 1);
        one_line();
        @(negedge clk) cal_n = 1'b0;
        @(negedge clk) cal_n = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        check("R10", "flag after clear", flag, 0);
        check("R10", "avg kept after clear", avg, 77);
        // R10 clear wins over simultaneous strobe
        @(negedge clk) begin cal_n = 1'b0; clr = 1'b1; end
        @(negedge clk) begin cal_n = 1'b1; clr = 1'b0; end
        check("R10", "no window on clear+strobe", flag, 0);
        // line count restarted: one-line set completes after one line
        pval = 300; set_cfg(1, 0, 0);
        one_line();
        wait_done("R10");
        check("R10", "fresh set average", avg, 300);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule